// File: doc/BRIEF.md
# Multi-Bank Interrupt Controller with Ranked Parent Output

This block collects interrupt sources that are organised into several identical banks, by default five banks of 32 sources each. Each source has its own enable, trigger mode (level or edge) and polarity (active high/rising or active low/falling). Each bank ANDs its per-source pending state with its enables and drives a single request line. A registered parent stage ranks a separate timer line above every bank and ranks banks by ascending number. It then reports the winning cause together with the lowest numbered enabled pending source inside the winning bank. When nothing is pending, it raises a spurious flag instead.

Software reaches each bank through a plain word-addressed read/write port. Bank `b` occupies `BANK_STRIDE` bytes starting at byte address `b*BANK_STRIDE`. Edge-triggered sources latch a pending bit that software clears by writing ones. Writing ones to a set register forces pending bits from software. Every external source input passes through a synchronizer chain before it is used.

Top module: `intc_bank_top`

## Requirements
- R1: Bank `b` decodes byte address `b*24 + off`. The offsets are: 0x00 status (read only, writes ignored), 0x04 enable, 0x08 set, 0x0C clear, 0x10 polarity and 0x14 trigger mode. Any address that is unaligned or outside these six words reads 0, and a write to it changes nothing.
- R2: Reset values are as follows. All enables are 0 and all polarity bits are 1. All mode bits are 0 except bank 0 bits 13..15, so bank 0 reads 0x0000E000. All status bits read 0. While reset is held, `irq_valid` and `irq_spurious` are both 0.
- R3: A source whose mode bit is 0 is level triggered. Its status bit equals the input when its polarity bit is 1 and the inverted input when its polarity bit is 0. An input change shows in status after exactly two rising clock edges.
- R4: A source whose mode bit is 1 is edge triggered. With polarity 1, a 0-to-1 input transition latches its status bit. With polarity 0, a 1-to-0 transition latches it. The opposite transition does not latch the bit and does not release it.
- R5: Writing the clear register drops the latched status bits where the data has a 1. Bits where the data has a 0 are unaffected. An edge that arrives in the same cycle as the clear write stays latched.
- R6: Writing the set register forces the status bits where the data has a 1 and leaves the others alone. Reads of the set and clear registers return 0.
- R7: `bank_req[b]` is 1 exactly when bank `b` has a status bit that is also enabled. A pending bit whose enable is 0 raises nothing.
- R8: When a bank wins, `irq_src` is the lowest bit index set in that bank's status AND enable.
- R9: The timer ranks above every bank. The banks rank from bank 0 upward. A timer win gives `irq_timer`=1 with `irq_bank`=0 and `irq_src`=0.
- R10: When neither the timer nor any bank requests, `irq_spurious`=1 and `irq_valid`, `irq_timer`, `irq_bank` and `irq_src` are 0. After reset, exactly one of `irq_valid` and `irq_spurious` is 1.
- R11: The `irq_*` outputs are registered. They show the timer line and the bank requests as they stood one clock edge earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, sampled on the rising edge |
| reg_addr | input | ADDR_W (7) | Byte address of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| src_in | input | NUM_BANKS*SRC_W (160) | Asynchronous source inputs; bank b bit i is `src_in[b*SRC_W+i]` |
| timer_req | input | 1 | Timer request, ranked above every bank |
| bank_req | output | NUM_BANKS (5) | Per-bank combined request |
| irq_valid | output | 1 | A cause was selected |
| irq_timer | output | 1 | The selected cause is the timer |
| irq_bank | output | BANK_IW (3) | Winning bank number |
| irq_src | output | SRC_IW (5) | Lowest enabled pending source in the winning bank |
| irq_spurious | output | 1 | Nothing was pending |

## Verification
A level input reaches status two rising edges after it is driven and reaches the `irq_*` outputs on the third. An edge input reaches status one edge later than a level input, because the latch adds a register. A set or clear write changes status at the edge that samples it, and the registered outputs follow one edge after that. The bench samples only at falling edges. It checks the two-edge level delay and the one-edge output delay at exactly those edges, with the value before the change checked one edge earlier. It compares the same-cycle edge and clear case by placing the write strobe on the edge where the edge event is present. The priority table waits four edges after each stimulus so that every path has settled before it compares.

// File: rtl/intc_pkg.sv
package intc_pkg;

   localparam int DATA_W        = 32;
   localparam int REGS_PER_BANK = 6;
   localparam int MIN_STRIDE    = REGS_PER_BANK * 4;

   // word index inside one bank's window; the decoder depends on this order
   typedef enum logic [2:0] {
      REG_STAT = 3'd0,
      REG_ENAB = 3'd1,
      REG_SETP = 3'd2,
      REG_CLRP = 3'd3,
      REG_POLR = 3'd4,
      REG_MODE = 3'd5
   } reg_sel_e;

endpackage

// File: rtl/intc_addr_dec.sv
module intc_addr_dec
   import intc_pkg::*;
#(
   parameter int NUM_BANKS   = 5,
   parameter int BANK_STRIDE = 24,
   parameter int ADDR_W      = 7
)(
   input  logic [ADDR_W-1:0]    addr,
   output logic [NUM_BANKS-1:0] bank_hit,
   output reg_sel_e             reg_sel
);

   always_comb begin
      bank_hit = '0;
      reg_sel  = REG_STAT;
      for (int b = 0; b < NUM_BANKS; b++) begin
         for (int k = 0; k < REGS_PER_BANK; k++) begin
            if (addr == ADDR_W'(b * BANK_STRIDE + 4 * k)) begin
               bank_hit[b] = 1'b1;
               reg_sel     = reg_sel_e'(3'(k));
            end
         end
      end
   end

endmodule

// File: rtl/intc_src_bank.sv
module intc_src_bank
   import intc_pkg::*;
#(
   parameter int               SRC_W       = 32,
   parameter int               SYNC_STAGES = 2,
   parameter logic [SRC_W-1:0] MODE_RST    = '0
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic [SRC_W-1:0]   src_raw,
   input  logic               wr_en,
   input  reg_sel_e           rsel,
   input  logic [SRC_W-1:0]   wdata,
   output logic [DATA_W-1:0]  rdata,
   output logic [SRC_W-1:0]   req_vec
);

   logic [SRC_W-1:0] sync_q [SYNC_STAGES];
   logic [SRC_W-1:0] samp_d;
   logic [SRC_W-1:0] samp;
   logic [SRC_W-1:0] en_q, pol_q, mode_q, lat_q;
   logic [SRC_W-1:0] set_mask, clr_mask;
   logic [SRC_W-1:0] act, rise, fall, edge_ev, status;

   // synchronizer chain plus one history stage for edge detection
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < SYNC_STAGES; s++) sync_q[s] <= '0;
         samp_d <= '0;
      end else begin
         sync_q[0] <= src_raw;
         for (int s = 1; s < SYNC_STAGES; s++) sync_q[s] <= sync_q[s-1];
         samp_d <= sync_q[SYNC_STAGES-1];
      end
   end

   assign samp    = sync_q[SYNC_STAGES-1];
   assign act     = ~(samp ^ pol_q);
   assign rise    = samp & ~samp_d;
   assign fall    = ~samp & samp_d;
   assign edge_ev = mode_q & ((pol_q & rise) | (~pol_q & fall));

   always_comb begin
      set_mask = '0;
      clr_mask = '0;
      if (wr_en && rsel == REG_SETP) set_mask = wdata;
      if (wr_en && rsel == REG_CLRP) clr_mask = wdata;
   end

   // configuration registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= '0;
         pol_q  <= '1;
         mode_q <= MODE_RST;
      end else if (wr_en) begin
         case (rsel)
            REG_ENAB: en_q   <= wdata;
            REG_POLR: pol_q  <= wdata;
            REG_MODE: mode_q <= wdata;
            default:  ;
         endcase
      end
   end

   // pending latch: a new edge or a software set beats a clear in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lat_q <= '0;
      else        lat_q <= (lat_q & ~clr_mask) | edge_ev | set_mask;
   end

   assign status  = lat_q | (act & ~mode_q);
   assign req_vec = status & en_q;

   always_comb begin
      rdata = '0;
      case (rsel)
         REG_STAT: rdata[SRC_W-1:0] = status;
         REG_ENAB: rdata[SRC_W-1:0] = en_q;
         REG_POLR: rdata[SRC_W-1:0] = pol_q;
         REG_MODE: rdata[SRC_W-1:0] = mode_q;
         default:  rdata = '0;
      endcase
   end

endmodule

// File: rtl/intc_prio_sel.sv
module intc_prio_sel #(
   parameter int NUM_BANKS = 5,
   parameter int SRC_W     = 32,
   parameter int BANK_IW   = 3,
   parameter int SRC_IW    = 5
)(
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       timer_req,
   input  logic [NUM_BANKS*SRC_W-1:0] req_vecs,
   output logic [NUM_BANKS-1:0]       bank_req,
   output logic                       irq_valid,
   output logic                       irq_timer,
   output logic [BANK_IW-1:0]         irq_bank,
   output logic [SRC_IW-1:0]          irq_src,
   output logic                       irq_spurious
);

   logic [NUM_BANKS*SRC_IW-1:0] low_idx;
   logic                        win_any;
   logic [BANK_IW-1:0]          win_bank;
   logic [SRC_IW-1:0]           win_src;

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_find
      logic [SRC_IW-1:0] idx;
      always_comb begin
         idx = '0;
         for (int i = SRC_W - 1; i >= 0; i--)
            if (req_vecs[b*SRC_W + i]) idx = SRC_IW'(i);
      end
      assign low_idx[b*SRC_IW +: SRC_IW] = idx;
      assign bank_req[b] = |req_vecs[b*SRC_W +: SRC_W];
   end

   always_comb begin
      win_any  = 1'b0;
      win_bank = '0;
      for (int b = NUM_BANKS - 1; b >= 0; b--) begin
         if (bank_req[b]) begin
            win_any  = 1'b1;
            win_bank = BANK_IW'(b);
         end
      end
   end

   assign win_src = low_idx[win_bank*SRC_IW +: SRC_IW];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_valid    <= 1'b0;
         irq_timer    <= 1'b0;
         irq_bank     <= '0;
         irq_src      <= '0;
         irq_spurious <= 1'b0;
      end else if (timer_req) begin
         irq_valid    <= 1'b1;
         irq_timer    <= 1'b1;
         irq_bank     <= '0;
         irq_src      <= '0;
         irq_spurious <= 1'b0;
      end else if (win_any) begin
         irq_valid    <= 1'b1;
         irq_timer    <= 1'b0;
         irq_bank     <= win_bank;
         irq_src      <= win_src;
         irq_spurious <= 1'b0;
      end else begin
         irq_valid    <= 1'b0;
         irq_timer    <= 1'b0;
         irq_bank     <= '0;
         irq_src      <= '0;
         irq_spurious <= 1'b1;
      end
   end

endmodule

// File: rtl/intc_bank_top.sv
module intc_bank_top
   import intc_pkg::*;
#(
   parameter int                         NUM_BANKS   = 5,
   parameter int                         SRC_W       = 32,
   parameter int                         BANK_STRIDE = 24,
   parameter int                         SYNC_STAGES = 2,
   parameter logic [NUM_BANKS*SRC_W-1:0] MODE_RST    = 'h0000_E000,
   localparam int ADDR_W  = $clog2(NUM_BANKS * BANK_STRIDE),
   localparam int BANK_IW = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
   localparam int SRC_IW  = $clog2(SRC_W)
)(
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       reg_wr,
   input  logic [ADDR_W-1:0]          reg_addr,
   input  logic [31:0]                reg_wdata,
   output logic [31:0]                reg_rdata,
   input  logic [NUM_BANKS*SRC_W-1:0] src_in,
   input  logic                       timer_req,
   output logic [NUM_BANKS-1:0]       bank_req,
   output logic                       irq_valid,
   output logic                       irq_timer,
   output logic [BANK_IW-1:0]         irq_bank,
   output logic [SRC_IW-1:0]          irq_src,
   output logic                       irq_spurious
);

   if (SRC_W < 2 || SRC_W > DATA_W) begin : g_bad_width
      $error("SRC_W must lie between 2 and the register width");
   end
   if (BANK_STRIDE < MIN_STRIDE || (BANK_STRIDE % 4) != 0) begin : g_bad_stride
      $error("BANK_STRIDE must be word aligned and hold six registers");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (NUM_BANKS < 1) begin : g_bad_banks
      $error("NUM_BANKS must be at least 1");
   end

   logic [NUM_BANKS-1:0]       bank_hit;
   reg_sel_e                   reg_sel;
   logic [DATA_W-1:0]          bank_rd [NUM_BANKS];
   logic [NUM_BANKS*SRC_W-1:0] req_flat;

   intc_addr_dec #(
      .NUM_BANKS   (NUM_BANKS),
      .BANK_STRIDE (BANK_STRIDE),
      .ADDR_W      (ADDR_W)
   ) u_dec (
      .addr     (reg_addr),
      .bank_hit (bank_hit),
      .reg_sel  (reg_sel)
   );

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      intc_src_bank #(
         .SRC_W       (SRC_W),
         .SYNC_STAGES (SYNC_STAGES),
         .MODE_RST    (MODE_RST[b*SRC_W +: SRC_W])
      ) u_bank (
         .clk     (clk),
         .rst_n   (rst_n),
         .src_raw (src_in[b*SRC_W +: SRC_W]),
         .wr_en   (reg_wr & bank_hit[b]),
         .rsel    (reg_sel),
         .wdata   (reg_wdata[SRC_W-1:0]),
         .rdata   (bank_rd[b]),
         .req_vec (req_flat[b*SRC_W +: SRC_W])
      );
   end

   always_comb begin
      reg_rdata = '0;
      for (int b = 0; b < NUM_BANKS; b++)
         if (bank_hit[b]) reg_rdata = reg_rdata | bank_rd[b];
   end

   intc_prio_sel #(
      .NUM_BANKS (NUM_BANKS),
      .SRC_W     (SRC_W),
      .BANK_IW   (BANK_IW),
      .SRC_IW    (SRC_IW)
   ) u_prio (
      .clk          (clk),
      .rst_n        (rst_n),
      .timer_req    (timer_req),
      .req_vecs     (req_flat),
      .bank_req     (bank_req),
      .irq_valid    (irq_valid),
      .irq_timer    (irq_timer),
      .irq_bank     (irq_bank),
      .irq_src      (irq_src),
      .irq_spurious (irq_spurious)
   );

endmodule

// File: rtl/intc_bank_chk.sv
module intc_bank_chk #(
   parameter int NUM_BANKS = 5,
   parameter int SRC_W     = 32,
   localparam int BANK_IW  = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
   localparam int SRC_IW   = $clog2(SRC_W)
)(
   input logic                 clk,
   input logic                 rst_n,
   input logic                 timer_req,
   input logic [NUM_BANKS-1:0] bank_req,
   input logic                 irq_valid,
   input logic                 irq_timer,
   input logic [BANK_IW-1:0]   irq_bank,
   input logic [SRC_IW-1:0]    irq_src,
   input logic                 irq_spurious
);

   logic                 armed;
   logic [NUM_BANKS-1:0] hit_mask, below_mask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   always_comb begin
      for (int b = 0; b < NUM_BANKS; b++) begin
         hit_mask[b]   = (irq_bank == BANK_IW'(b));
         below_mask[b] = (BANK_IW'(b) < irq_bank);
      end
   end

   AST_TIMER_WINS: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      $past(timer_req) |-> (irq_valid && irq_timer)); // R9

   AST_BANK_ORDER: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      (irq_valid && !irq_timer) |->
         ((($past(bank_req) & hit_mask) != '0) && (($past(bank_req) & below_mask) == '0))); // R9

   AST_SPUR_FIELDS: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      irq_spurious |-> (!irq_valid && !irq_timer && irq_bank == '0 && irq_src == '0)); // R10

   AST_SPUR_NO_CAUSE: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      irq_spurious |-> (!$past(timer_req) && $past(bank_req) == '0)); // R10

   AST_VALID_OR_SPUR: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      irq_valid != irq_spurious); // R10

   AST_VALID_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      irq_valid |-> ($past(timer_req) || $past(bank_req) != '0)); // R11

endmodule

bind intc_bank_top intc_bank_chk #(
   .NUM_BANKS (NUM_BANKS),
   .SRC_W     (SRC_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .timer_req    (timer_req),
   .bank_req     (bank_req),
   .irq_valid    (irq_valid),
   .irq_timer    (irq_timer),
   .irq_bank     (irq_bank),
   .irq_src      (irq_src),
   .irq_spurious (irq_spurious)
);

// File: tb/intc_bank_top_tb.sv
`timescale 1ns/100ps
module intc_bank_top_tb_top;

   localparam int NB = 5;
   localparam int SW = 32;
   localparam int AW = 7;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           reg_wr = 1'b0;
   logic [AW-1:0]  reg_addr = '0;
   logic [31:0]    reg_wdata = '0;
   logic [31:0]    reg_rdata;
   logic [NB*SW-1:0] src_in = '0;
   logic           timer_req = 1'b0;
   logic [NB-1:0]  bank_req;
   logic           irq_valid, irq_timer, irq_spurious;
   logic [2:0]     irq_bank;
   logic [4:0]     irq_src;

   int n_chk  = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   intc_bank_top dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .reg_wr       (reg_wr),
      .reg_addr     (reg_addr),
      .reg_wdata    (reg_wdata),
      .reg_rdata    (reg_rdata),
      .src_in       (src_in),
      .timer_req    (timer_req),
      .bank_req     (bank_req),
      .irq_valid    (irq_valid),
      .irq_timer    (irq_timer),
      .irq_bank     (irq_bank),
      .irq_src      (irq_src),
      .irq_spurious (irq_spurious)
   );

   // offsets inside a bank window
   localparam int O_STAT = 0, O_ENAB = 4, O_SETP = 8, O_CLRP = 12, O_POLR = 16, O_MODE = 20;

   typedef struct packed {
      logic       tmr;
      logic [2:0] ba;  // 7 = none
      logic [4:0] ia;
      logic [2:0] bb;  // 7 = none
      logic [4:0] ib;
      logic [4:0] ic;  // second bit in bank ba
      logic       ev;
      logic       et;
      logic [2:0] eb;
      logic [4:0] es;
   } vec_t;

   localparam int NV = 8;
   localparam vec_t VECS [NV] = '{
      '{1'b0, 3'd7, 5'd0,  3'd7, 5'd0,  5'd0,  1'b0, 1'b0, 3'd0, 5'd0},
      '{1'b1, 3'd7, 5'd0,  3'd7, 5'd0,  5'd0,  1'b1, 1'b1, 3'd0, 5'd0},
      '{1'b0, 3'd2, 5'd7,  3'd7, 5'd0,  5'd7,  1'b1, 1'b0, 3'd2, 5'd7},
      '{1'b0, 3'd2, 5'd7,  3'd7, 5'd0,  5'd3,  1'b1, 1'b0, 3'd2, 5'd3},
      '{1'b0, 3'd3, 5'd0,  3'd1, 5'd31, 5'd0,  1'b1, 1'b0, 3'd1, 5'd31},
      '{1'b1, 3'd0, 5'd5,  3'd7, 5'd0,  5'd5,  1'b1, 1'b1, 3'd0, 5'd0},
      '{1'b0, 3'd4, 5'd20, 3'd7, 5'd0,  5'd9,  1'b1, 1'b0, 3'd4, 5'd9},
      '{1'b0, 3'd0, 5'd0,  3'd4, 5'd0,  5'd0,  1'b1, 1'b0, 3'd0, 5'd0}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk);
      reg_addr  = AW'(a);
      reg_wdata = d;
      reg_wr    = 1'b1;
      @(negedge clk);
      reg_wr    = 1'b0;
   endtask

   task automatic rd_chk(input string req, input int a, input logic [31:0] exp);
      reg_addr = AW'(a);
      #1;
      chk(req, reg_rdata, exp);
   endtask

   task automatic out_chk(input string req, input logic v, input logic t,
                          input logic [2:0] b, input logic [4:0] s, input logic sp);
      chk({req, " valid"},    32'(irq_valid),    32'(v));
      chk({req, " timer"},    32'(irq_timer),    32'(t));
      chk({req, " bank"},     32'(irq_bank),     32'(b));
      chk({req, " src"},      32'(irq_src),      32'(s));
      chk({req, " spurious"}, 32'(irq_spurious), 32'(sp));
   endtask

   function automatic int ad(input int bank, input int off);
      return bank * 24 + off;
   endfunction

   bit finished = 1'b0;

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      // ---------------- reset state (R2) ----------------
      repeat (3) @(negedge clk);
      chk("R2 valid in reset", 32'(irq_valid), 0);
      chk("R2 spurious in reset", 32'(irq_spurious), 0);
      rst_n = 1'b1;
      rd_chk("R2 enable b0", ad(0, O_ENAB), 32'h0);
      rd_chk("R2 polarity b2", ad(2, O_POLR), 32'hFFFF_FFFF);
      rd_chk("R2 mode b0", ad(0, O_MODE), 32'h0000_E000);
      rd_chk("R2 mode b4", ad(4, O_MODE), 32'h0);
      rd_chk("R2 status b0", ad(0, O_STAT), 32'h0);
      @(negedge clk);
      out_chk("R10 idle after reset", 1'b0, 1'b0, 3'd0, 5'd0, 1'b1);

      // ---------------- address map (R1) ----------------
      wr(ad(1, O_ENAB), 32'h0000_005A);
      rd_chk("R1 enable b1", ad(1, O_ENAB), 32'h0000_005A);
      rd_chk("R1 enable b0 separate", ad(0, O_ENAB), 32'h0);
      wr(ad(1, O_ENAB) + 1, 32'hFFFF_FFFF);
      rd_chk("R1 unaligned write ignored", ad(1, O_ENAB), 32'h0000_005A);
      rd_chk("R1 out of range read", 120, 32'h0);
      wr(ad(2, O_STAT), 32'hFFFF_FFFF);
      rd_chk("R1 status read only", ad(2, O_STAT), 32'h0);
      rd_chk("R6 set reads zero", ad(2, O_SETP), 32'h0);

      // ---------------- setup: all level, all enabled ----------------
      wr(ad(0, O_MODE), 32'h0);
      for (int b = 0; b < NB; b++) wr(ad(b, O_ENAB), 32'hFFFF_FFFF);

      // ---------------- priority table (R7 R8 R9 R10) ----------------
      for (int v = 0; v < NV; v++) begin
         logic [NB*SW-1:0] s;
         logic [NB-1:0]    eq;
         s  = '0;
         eq = '0;
         if (VECS[v].ba != 3'd7) begin
            s[int'(VECS[v].ba)*SW + int'(VECS[v].ia)] = 1'b1;
            s[int'(VECS[v].ba)*SW + int'(VECS[v].ic)] = 1'b1;
            eq[VECS[v].ba] = 1'b1;
         end
         if (VECS[v].bb != 3'd7) begin
            s[int'(VECS[v].bb)*SW + int'(VECS[v].ib)] = 1'b1;
            eq[VECS[v].bb] = 1'b1;
         end
         @(negedge clk);
         src_in    = s;
         timer_req = VECS[v].tmr;
         repeat (4) @(negedge clk);
         chk($sformatf("R7 bank_req vec %0d", v), 32'(bank_req), 32'(eq));
         out_chk($sformatf("R8 R9 R10 vec %0d", v), VECS[v].ev, VECS[v].et,
                 VECS[v].eb, VECS[v].es, !VECS[v].ev);
         src_in    = '0;
         timer_req = 1'b0;
         repeat (4) @(negedge clk);
      end

      // ---------------- level polarity and sync delay (R3) ----------------
      wr(ad(1, O_POLR), 32'hFFFF_FFFE);
      rd_chk("R3 active-low idle", ad(1, O_STAT), 32'h1);
      src_in[SW + 0] = 1'b1;
      @(negedge clk);
      rd_chk("R3 one edge later unchanged", ad(1, O_STAT), 32'h1);
      @(negedge clk);
      rd_chk("R3 two edges later updated", ad(1, O_STAT), 32'h0);
      wr(ad(1, O_POLR), 32'hFFFF_FFFF);
      rd_chk("R3 active-high follows input", ad(1, O_STAT), 32'h1);
      src_in[SW + 0] = 1'b0;
      repeat (3) @(negedge clk);

      // ---------------- set register and output delay (R6 R11) ----------------
      wr(ad(3, O_SETP), 32'h0000_0400);
      chk("R11 output not yet", 32'(irq_valid), 0);
      @(negedge clk);
      out_chk("R6 R11 set raises", 1'b1, 1'b0, 3'd3, 5'd10, 1'b0);
      rd_chk("R6 status after set", ad(3, O_STAT), 32'h0000_0400);
      wr(ad(3, O_SETP), 32'h0);
      rd_chk("R6 zero set no effect", ad(3, O_STAT), 32'h0000_0400);
      wr(ad(3, O_CLRP), 32'h0000_0400);
      rd_chk("R5 clear set bit", ad(3, O_STAT), 32'h0);
      rd_chk("R6 clear reads zero", ad(3, O_CLRP), 32'h0);

      // ---------------- edge mode (R4 R5) ----------------
      wr(ad(1, O_MODE), 32'h0000_0010);
      src_in[SW + 4] = 1'b1;
      repeat (4) @(negedge clk);
      rd_chk("R4 rising latched", ad(1, O_STAT), 32'h10);
      src_in[SW + 4] = 1'b0;
      repeat (4) @(negedge clk);
      rd_chk("R4 held after input falls", ad(1, O_STAT), 32'h10);
      wr(ad(1, O_CLRP), 32'h0000_0010);
      rd_chk("R5 clear edge bit", ad(1, O_STAT), 32'h0);
      wr(ad(1, O_POLR), 32'hFFFF_FFEF);
      src_in[SW + 4] = 1'b1;
      repeat (4) @(negedge clk);
      rd_chk("R4 rising ignored when falling", ad(1, O_STAT), 32'h0);
      src_in[SW + 4] = 1'b0;
      repeat (4) @(negedge clk);
      rd_chk("R4 falling latched", ad(1, O_STAT), 32'h10);
      wr(ad(1, O_POLR), 32'hFFFF_FFFF);
      wr(ad(1, O_CLRP), 32'h0000_0010);

      // partial clear
      wr(ad(1, O_MODE), 32'h0000_0050);
      src_in[SW + 4] = 1'b1;
      src_in[SW + 6] = 1'b1;
      repeat (4) @(negedge clk);
      src_in[SW + 4] = 1'b0;
      src_in[SW + 6] = 1'b0;
      repeat (4) @(negedge clk);
      rd_chk("R5 both latched", ad(1, O_STAT), 32'h50);
      wr(ad(1, O_CLRP), 32'h0000_0010);
      rd_chk("R5 zero bits untouched", ad(1, O_STAT), 32'h40);
      wr(ad(1, O_CLRP), 32'h0000_0040);

      // edge arriving in the same cycle as the clear write
      src_in[SW + 4] = 1'b1;
      repeat (2) @(negedge clk);
      reg_addr  = AW'(ad(1, O_CLRP));
      reg_wdata = 32'h0000_0010;
      reg_wr    = 1'b1;
      @(negedge clk);
      reg_wr    = 1'b0;
      rd_chk("R5 edge beats clear", ad(1, O_STAT), 32'h10);
      src_in[SW + 4] = 1'b0;
      wr(ad(1, O_CLRP), 32'h0000_0010);
      wr(ad(1, O_MODE), 32'h0);

      // ---------------- enable gating (R7) ----------------
      wr(ad(2, O_ENAB), 32'h0);
      wr(ad(2, O_SETP), 32'h0000_0001);
      repeat (2) @(negedge clk);
      chk("R7 disabled bank quiet", 32'(bank_req), 0);
      out_chk("R7 disabled gives spurious", 1'b0, 1'b0, 3'd0, 5'd0, 1'b1);
      wr(ad(2, O_ENAB), 32'h0000_0001);
      @(negedge clk);
      out_chk("R7 enabled raises", 1'b1, 1'b0, 3'd2, 5'd0, 1'b0);
      wr(ad(2, O_CLRP), 32'h0000_0001);

      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule